// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a peripheral bus clock from the parent clock it runs on. It has a programmable integer ratio from 1 to 128 and an output gate. The block drives two outputs. `pb_level_o` is the divided clock waveform, registered in the parent domain. `pb_tick_o` is a one-cycle strobe at the start of every output period, which bus logic can use as a clock enable.

Software reaches the block through one 16-bit control word. The word holds a 7-bit ratio field, a read-only ready flag and an enable bit. A write can replace the word, set chosen bits or clear chosen bits, so single bits change without a read-modify-write. The ratio field accepts a change only while the external `unlock_i` flag is high. The enable bit needs no unlock.

A new ratio or enable value is held back until the current output period ends, so the output never shows a truncated pulse. A small sequencer tracks whether a requested ratio is still waiting for that boundary. It has two states. `ST_STEADY` reports ready high. `ST_PENDING` reports ready low. The sequencer moves from ST_STEADY to ST_PENDING on any accepted ratio write. It returns from ST_PENDING to ST_STEADY at a period boundary in which no new ratio write arrives. A ratio write in ST_PENDING keeps the sequencer in ST_PENDING.

Top module: `pbclk_divider`

## Requirements
- R1: After reset the control word reads 0x0800: ratio field 0, ready (bit 11) high, enable (bit 15) low. Both outputs are low.
- R2: While enabled with applied field value F, `pb_tick_o` is high in exactly one cycle out of every F+1, in the first cycle of each output period.
- R3: Within each period, `pb_level_o` is high for the first ceil((F+1)/2) cycles and low for the rest. With F = 0, `pb_level_o` stays high.
- R4: A write with `unlock_i` low leaves the ratio field (bits 6:0) and the ready flag unchanged.
- R5: `wr_op_i` selects the write kind: 0 replaces the word, 1 ORs the ones in `wr_data_i` into the word, 2 clears the bits that are one in `wr_data_i`, and 3 changes nothing. A set or clear write with a zero ratio part does not touch the ratio field.
- R6: An accepted ratio write drives ready low in the next cycle. The field reads the requested value at once. Ready returns high after the period boundary that loads the new ratio.
- R7: A new ratio is loaded only when the current period ends. The period in progress completes at the old length.
- R8: With the applied enable low, both outputs stay low. A change of bit 15 is applied at a period boundary, so a high phase of the level is never cut short.
- R9: A ratio write in the same cycle as a period boundary is not loaded at that boundary. Ready stays low until the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_op_i | input | 2 | Write kind: 0 replace, 1 set, 2 clear, 3 none |
| wr_data_i | input | 16 | Write data |
| unlock_i | input | 1 | Permits changes to the ratio field |
| rd_data_o | output | 16 | Control word read value |
| pb_level_o | output | 1 | Divided clock waveform |
| pb_tick_o | output | 1 | Period-start strobe |

## Verification
A write presented before a parent clock edge appears in `rd_data_o` right after that edge. This includes the fall of ready. The applied ratio and enable move only on the edge that ends a period, which is the edge where the counter equals the applied field value. The level and tick follow on that same edge with no further register stage. The bench drives inputs and compares the outputs at the falling edge. A behavioural model is stepped once per rising edge, so every result is checked in the first half-cycle in which it is due. Directed checks time boundary writes by watching `pb_tick_o`, and they count cycles between ticks to confirm period lengths.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;

    // Write kinds for the control word
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

    // Ratio-change sequencer states
    typedef enum logic {
        ST_STEADY  = 1'b0,
        ST_PENDING = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pbdiv_regs.sv
module pbdiv_regs
    import pbdiv_pkg::*;
#(
    parameter int DIV_W  = 7,
    parameter int REG_W  = 16,
    parameter int EN_BIT = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_op_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             unlock_i,
    output logic [DIV_W-1:0] req_div_o,
    output logic             en_req_o,
    output logic             field_wr_o
);

    logic [DIV_W-1:0] div_q, div_d;
    logic             en_q, en_d;
    logic [DIV_W-1:0] wdiv;
    logic             wen;
    wr_op_e           op;

    assign wdiv = wr_data_i[DIV_W-1:0];
    assign wen  = wr_data_i[EN_BIT];
    assign op   = wr_op_e'(wr_op_i);

    // Decode the write kind into new field and enable values
    always_comb begin
        div_d      = div_q;
        en_d       = en_q;
        field_wr_o = 1'b0;
        if (wr_en_i) begin
            unique case (op)
                OP_WRITE: begin
                    en_d = wen;
                    if (unlock_i) begin
                        div_d      = wdiv;
                        field_wr_o = 1'b1;
                    end
                end
                OP_SET: begin
                    en_d = en_q | wen;
                    if (unlock_i && (|wdiv)) begin
                        div_d      = div_q | wdiv;
                        field_wr_o = 1'b1;
                    end
                end
                OP_CLR: begin
                    en_d = en_q & ~wen;
                    if (unlock_i && (|wdiv)) begin
                        div_d      = div_q & ~wdiv;
                        field_wr_o = 1'b1;
                    end
                end
                OP_NONE: begin
                    div_d = div_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= '0;
            en_q  <= 1'b0;
        end else begin
            div_q <= div_d;
            en_q  <= en_d;
        end
    end

    assign req_div_o = div_q;
    assign en_req_o  = en_q;

endmodule

// File: rtl/pbdiv_seq.sv
module pbdiv_seq
    import pbdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic field_wr_i,
    input  logic boundary_i,
    output logic ready_o
);

    seq_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY: begin
                if (field_wr_i) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (boundary_i && !field_wr_i) state_d = ST_STEADY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_STEADY;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        ready_o = 1'b1;
        unique case (state_q)
            ST_STEADY:  ready_o = 1'b1;
            ST_PENDING: ready_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pbdiv_counter.sv
module pbdiv_counter #(
    parameter int DIV_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] req_div_i,
    input  logic             en_req_i,
    output logic             boundary_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] act_div_o,
    output logic             en_act_o,
    output logic             level_o,
    output logic             tick_o
);

    localparam int HW = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q, act_q;
    logic             en_q;
    logic [HW-1:0]    high_len;

    assign boundary_o = (cnt_q == act_q);

    // Period counter; ratio and gate load only at the period end
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            act_q <= '0;
            en_q  <= 1'b0;
        end else if (boundary_o) begin
            cnt_q <= '0;
            act_q <= req_div_i;
            en_q  <= en_req_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High phase length = ceil(ratio / 2), ratio = act + 1
    assign high_len = HW'((({1'b0, act_q}) + HW'(2)) >> 1);

    always_comb begin
        level_o = en_q && ({1'b0, cnt_q} < high_len);
        tick_o  = en_q && (cnt_q == '0);
    end

    assign cnt_o     = cnt_q;
    assign act_div_o = act_q;
    assign en_act_o  = en_q;

endmodule

// File: rtl/pbclk_divider.sv
module pbclk_divider #(
    parameter int DIV_W   = 7,
    parameter int REG_W   = 16,
    parameter int RDY_BIT = 11,
    parameter int EN_BIT  = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_op_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             unlock_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             pb_level_o,
    output logic             pb_tick_o
);

    logic [DIV_W-1:0] req_div, act_div, cnt;
    logic             en_req, en_act, field_wr, boundary, ready;

    pbdiv_regs #(.DIV_W(DIV_W), .REG_W(REG_W), .EN_BIT(EN_BIT)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_op_i    (wr_op_i),
        .wr_data_i  (wr_data_i),
        .unlock_i   (unlock_i),
        .req_div_o  (req_div),
        .en_req_o   (en_req),
        .field_wr_o (field_wr)
    );

    pbdiv_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .field_wr_i (field_wr),
        .boundary_i (boundary),
        .ready_o    (ready)
    );

    pbdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_div_i  (req_div),
        .en_req_i   (en_req),
        .boundary_o (boundary),
        .cnt_o      (cnt),
        .act_div_o  (act_div),
        .en_act_o   (en_act),
        .level_o    (pb_level_o),
        .tick_o     (pb_tick_o)
    );

    // Read-back assembly
    always_comb begin
        rd_data_o                = '0;
        rd_data_o[DIV_W-1:0]     = req_div;
        rd_data_o[RDY_BIT]       = ready;
        rd_data_o[EN_BIT]        = en_req;
    end

endmodule

// File: rtl/pbdiv_chk.sv
module pbdiv_chk #(
    parameter int DIV_W   = 7,
    parameter int REG_W   = 16,
    parameter int RDY_BIT = 11
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       wr_op_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic             unlock_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic             pb_level_o,
    input logic             pb_tick_o,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] act_div,
    input logic             en_act
);

    logic accepted;
    assign accepted = wr_en_i && unlock_i &&
        ((wr_op_i == 2'd0) || ((wr_op_i != 2'd3) && (|wr_data_i[DIV_W-1:0])));

    // R6: accepted ratio write drops ready on the next cycle
    a_r6_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accepted |=> !rd_data_o[RDY_BIT]);

    // R4: locked writes leave the ratio field alone
    a_r4_locked_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !unlock_i) |=> $stable(rd_data_o[DIV_W-1:0]));

    // R7: applied ratio only moves at a period end
    a_r7_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt != act_div) |=> $stable(act_div));

    // R8: gated output is quiet
    a_r8_gated_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_act |-> (!pb_level_o && !pb_tick_o));

    // R3: period start lies in the high phase
    a_r3_tick_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pb_tick_o |-> pb_level_o);

    // R2: counter never passes the applied ratio
    a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= act_div);

endmodule

bind pbclk_divider pbdiv_chk #(.DIV_W(DIV_W), .REG_W(REG_W), .RDY_BIT(RDY_BIT)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_op_i    (wr_op_i),
    .wr_data_i  (wr_data_i),
    .unlock_i   (unlock_i),
    .rd_data_o  (rd_data_o),
    .pb_level_o (pb_level_o),
    .pb_tick_o  (pb_tick_o),
    .cnt        (cnt),
    .act_div    (act_div),
    .en_act     (en_act)
);

// File: tb/pbclk_divider_tb.sv
`timescale 1ns/1ps
module pbclk_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = 2'd3;
    logic [15:0] wr_data = '0;
    logic        unlock = 1'b0;
    logic [15:0] rd_data;
    logic        level, tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural model state
    int m_req = 0, m_act = 0, m_cnt = 0;
    bit m_en = 0, m_ena = 0, m_pend = 0;

    always #2.5 clk = ~clk;

    pbclk_divider u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_op_i    (wr_op),
        .wr_data_i  (wr_data),
        .unlock_i   (unlock),
        .rd_data_o  (rd_data),
        .pb_level_o (level),
        .pb_tick_o  (tick)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd();
        return m_req | (m_pend ? 0 : 32'h800) | (m_en ? 32'h8000 : 0);
    endfunction

    task automatic compare_all();
        chk("R2 tick", int'(tick), int'(m_ena && m_cnt == 0));
        chk("R3 level", int'(level), int'(m_ena && (m_cnt < (m_act + 2) / 2)));
        chk("R6 read word", int'(rd_data), exp_rd());
    endtask

    task automatic model_step(input bit we, input int op, input int d, input bit ul);
        int  nreq = m_req;
        bit  nen  = m_en;
        bit  fw;
        bit  d15 = d[15];
        fw = we && ul && (op == 0 || (op != 3 && (d & 127) != 0));
        if (we) begin
            case (op)
                0: begin nen = d15; if (ul) nreq = d & 127; end
                1: begin nen = m_en | d15; if (ul) nreq = m_req | (d & 127); end
                2: begin nen = m_en & ~d15; if (ul) nreq = m_req & ~(d & 127) & 127; end
                default: ;
            endcase
        end
        if (m_cnt == m_act) begin
            m_cnt = 0;
            m_act = m_req;
            m_ena = m_en;
            if (!fw) m_pend = 0;
        end else begin
            m_cnt++;
        end
        if (fw) m_pend = 1;
        m_req = nreq;
        m_en  = nen;
    endtask

    task automatic cyc(input bit we, input int op, input int d, input bit ul);
        wr_en   = we;
        wr_op   = 2'(op);
        wr_data = 16'(d);
        unlock  = ul;
        model_step(we, op, d, ul);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_op = 2'd3;
        unlock = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3, 0, 0);
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 300 && !tick; i++) idle(1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 reset word", int'(rd_data), 32'h0800);
        chk("R1 reset level", int'(level), 0);
        chk("R1 reset tick", int'(tick), 0);

        // R4: locked replace sets enable but not the field
        cyc(1, 0, 32'h8003, 0);
        chk("R4 locked field", int'(rd_data[6:0]), 0);
        chk("R4 ready kept", int'(rd_data[11]), 1);
        idle(6);

        // R6: unlocked ratio 4
        cyc(1, 0, 32'h8003, 1);
        chk("R6 ready low", int'(rd_data[11]), 0);
        chk("R6 field readback", int'(rd_data[6:0]), 3);
        idle(20);
        chk("R6 ready high", int'(rd_data[11]), 1);

        // R5: set and clear aliases
        cyc(1, 1, 32'h0004, 1);
        chk("R5 set alias", int'(rd_data[6:0]), 7);
        idle(30);
        cyc(1, 2, 32'h0005, 1);
        chk("R5 clear alias", int'(rd_data[6:0]), 2);
        idle(20);
        cyc(1, 3, 32'hFFFF, 1);
        chk("R5 op none", int'(rd_data), 32'h8802);
        idle(5);

        // R8: gate off via clear alias, locked
        cyc(1, 2, 32'h8000, 0);
        idle(8);
        chk("R8 gated level", int'(level), 0);
        chk("R8 gated tick", int'(tick), 0);
        chk("R8 field kept", int'(rd_data[6:0]), 2);

        // R7: longest ratio, then change mid-period
        cyc(1, 0, 32'h807F, 1);
        idle(300);
        wait_tick();
        cyc(1, 0, 32'h8001, 1);
        chk("R7 ready low", int'(rd_data[11]), 0);
        n = 1;
        for (int i = 0; i < 300 && !tick; i++) begin idle(1); n++; end
        chk("R7 old period length", n, 128);
        idle(12);

        // R9: write exactly on the boundary of ratio 2
        wait_tick();
        idle(1);
        cyc(1, 0, 32'h8003, 1);
        chk("R9 ready low after boundary write", int'(rd_data[11]), 0);
        idle(1);
        chk("R9 ready still low", int'(rd_data[11]), 0);
        idle(1);
        chk("R9 ready high", int'(rd_data[11]), 1);

        // Mixed traffic
        for (int i = 0; i < 40; i++) cyc(1, i % 4, (i * 37) ^ 32'h8000, i[0]);
        idle(300);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule